// File: doc/BRIEF.md
# PWM Fault Trip and Re-arm Controller

This block sits between a three-phase PWM duty generator and the six gate-drive pins. It watches an active-low fault input. When that input goes low, all six gate outputs are pulled low at once through a purely combinational path, with no dependence on the clock. The outgoing sync pulse is blocked at the same moment.

A synchronized copy of the fault pin drives a latched tripped state. That state halts the timing unit (`run_o` low), clears the global enable and raises a sticky trip interrupt flag. Software clears each interrupt flag by writing 1 to it.

Recovery has two conditions. Software must write the period register and all three channel duty registers after the trip. The fault pin must also have returned high. Only then does the timing unit restart. Fresh duty values are taken at the next sync pulse that passes through.

The register write port decodes these addresses:
- 0: control, enable on bit 0.
- 1: status, write-one-to-clear.
- 2: period.
- 3, 4 and 5: the three channel duties.

Top module: `pwm_trip_ctrl`

## Requirements
- R1: While `trip_ni` is low, `gate_o` is all zeros in the same instant, with no clock edge needed. While the block is tripped or the enable is 0, `gate_o` is also zero. Otherwise `gate_o` equals `gate_i`.
- R2: `sync_o` is low whenever `trip_ni` is low or the block is tripped. Otherwise `sync_o` follows `sync_i` while the enable is set.
- R3: After `trip_ni` falls, the status pin copy (status bit 3) reads 0 after the second rising clock edge. On the third edge the block becomes tripped (`run_o` = 0) and the trip flag (status bit 8) becomes 1.
- R4: The trip event clears the enable (`en_o`). This holds even when a control write of enable = 1 lands on the same edge.
- R5: Once tripped, `run_o` returns to 1 one edge after both conditions hold: addresses 2, 3, 4 and 5 have each been written since the trip, and the synchronized pin is high. Writes made while the pin is still low count.
- R6: If any of the four timing registers has not been written since the latest trip, the block stays tripped even with the pin high. Writes made before the trip do not count.
- R7: Status bit 3 shows the synchronized pin level, and it reads 1 after reset. Status bit 9 (the sync flag) is set on the edge after a cycle in which `sync_o` was high.
- R8: Writing to address 1 with data bit 8 or bit 9 set clears the matching flag. A 0 in that bit leaves the flag unchanged. A flag set event on the same edge wins over the clear.
- R9: After reset: `en_o` = 0, `run_o` = 1, `status_o` = 16'h0008 when the pin is high, and `gate_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trip_ni | input | 1 | Active-low external fault pin |
| gate_i | input | 6 | Gate drives from the duty generator |
| sync_i | input | 1 | Sync pulse from the timing unit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| gate_o | output | 6 | Gated drives to the power stage |
| sync_o | output | 1 | Sync pulse, suppressed on fault |
| run_o | output | 1 | Timing unit run permission |
| en_o | output | 1 | Global PWM enable |
| status_o | output | 16 | Pin copy (bit 3), trip flag (bit 8), sync flag (bit 9) |

## Verification
Two things can fall on the same clock edge: the trip event, which sets the trip flag and clears the enable, and a software write to the status or control register. The bench times a status write-one-to-clear so that it lands on the third edge after the pin falls. It then expects the trip flag to read 1. In a separate trip, the bench times a control write of enable = 1 onto that same edge and expects `en_o` to read 0. A design that lets the software write win on that edge fails these checks.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 16;
  localparam int N_GATE  = 6;
  localparam int N_TREG  = 4;
  localparam int SYNC_STAGES = 2;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t ADDR_CTRL  = 3'd0;
  localparam addr_t ADDR_STAT  = 3'd1;
  localparam addr_t ADDR_TREG0 = 3'd2;  // period, then three duties

  localparam int CTRL_EN_BIT  = 0;
  localparam int ST_PIN_BIT   = 3;
  localparam int ST_TRIP_BIT  = 8;
  localparam int ST_SYNC_BIT  = 9;
endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // resets high so a healthy pin does not trip on reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rearm_tracker.sv
module rearm_tracker #(
  parameter int N_REG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_ok_i,
  input  logic [N_REG-1:0] reg_wr_i,
  output logic             tripped_o,
  output logic             trip_evt_o,
  output logic [N_REG-1:0] mask_o
);
  logic             tripped_q;
  logic [N_REG-1:0] mask_q;

  assign trip_evt_o = !pin_ok_i && !tripped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tripped_q <= 1'b0;
      mask_q    <= '0;
    end else if (trip_evt_o) begin
      tripped_q <= 1'b1;
      mask_q    <= '0;
    end else begin
      mask_q <= mask_q | reg_wr_i;
      if (tripped_q && pin_ok_i && (&mask_q)) tripped_q <= 1'b0;
    end
  end

  assign tripped_o = tripped_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/w1c_flags.sv
module w1c_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  // set has priority over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= set_i | (q & ~clr_i);
  end

  assign q_o = q;
endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
  import pwm_trip_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  trip_ni,
  input  logic [N_GATE-1:0]     gate_i,
  input  logic                  sync_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [N_GATE-1:0]     gate_o,
  output logic                  sync_o,
  output logic                  run_o,
  output logic                  en_o,
  output logic [DATA_W-1:0]     status_o
);
  logic              pin_s;
  logic              tripped;
  logic              trip_evt;
  logic [N_TREG-1:0] treg_wr;
  logic [N_TREG-1:0] wr_mask;
  logic              en_q;
  logic              pass;
  logic [1:0]        flag_set, flag_clr, flags;
  logic              stat_wr, ctrl_wr;
  logic              unused_data;

  assign unused_data = ^wr_data_i;

  trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trip_ni),
    .q_o   (pin_s)
  );

  for (genvar i = 0; i < N_TREG; i++) begin : g_treg
    assign treg_wr[i] = wr_en_i && (wr_addr_i == ADDR_TREG0 + ADDR_W'(i));
  end

  rearm_tracker #(.N_REG(N_TREG)) u_rearm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_ok_i  (pin_s),
    .reg_wr_i  (treg_wr),
    .tripped_o (tripped),
    .trip_evt_o(trip_evt),
    .mask_o    (wr_mask)
  );

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign stat_wr = wr_en_i && (wr_addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_q <= 1'b0;
    else if (trip_evt) en_q <= 1'b0;
    else if (ctrl_wr)  en_q <= wr_data_i[CTRL_EN_BIT];
  end

  // asynchronous kill: raw pin gates the outputs with no flop in the path
  assign pass   = trip_ni && !tripped && en_q;
  assign gate_o = pass ? gate_i : '0;
  assign sync_o = pass && sync_i;

  assign flag_set = {sync_o, trip_evt};
  assign flag_clr = {stat_wr && wr_data_i[ST_SYNC_BIT], stat_wr && wr_data_i[ST_TRIP_BIT]};

  w1c_flags #(.N(2)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flags)
  );

  always_comb begin
    status_o              = '0;
    status_o[ST_PIN_BIT]  = pin_s;
    status_o[ST_TRIP_BIT] = flags[0];
    status_o[ST_SYNC_BIT] = flags[1];
  end

  assign run_o = !tripped;
  assign en_o  = en_q;
endmodule

// File: rtl/pwm_trip_ctrl_chk.sv
module pwm_trip_ctrl_chk
  import pwm_trip_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trip_ni,
  input logic [N_GATE-1:0] gate_o,
  input logic              sync_o,
  input logic              run_o,
  input logic              en_o,
  input logic [DATA_W-1:0] status_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [N_TREG-1:0] wr_mask
);
  AST_GATE_OFF_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_ni |-> gate_o == '0);  // R1
  AST_GATE_OFF_TRIPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> gate_o == '0);  // R1
  AST_SYNC_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o || !trip_ni) |-> !sync_o);  // R2
  AST_TRIP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> status_o[ST_TRIP_BIT]);  // R3
  AST_TRIP_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> !en_o);  // R4
  AST_REARM_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> ($past(wr_mask) == '1) && $past(status_o[ST_PIN_BIT]));  // R5
  AST_SYNC_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> status_o[ST_SYNC_BIT]);  // R7
  AST_W1C_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_STAT && wr_data_i[ST_TRIP_BIT] && status_o[ST_PIN_BIT])
      |=> !status_o[ST_TRIP_BIT]);  // R8
endmodule

bind pwm_trip_ctrl pwm_trip_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .trip_ni  (trip_ni),
  .gate_o   (gate_o),
  .sync_o   (sync_o),
  .run_o    (run_o),
  .en_o     (en_o),
  .status_o (status_o),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .wr_mask  (wr_mask)
);

// File: tb/pwm_trip_ctrl_tb.sv
`timescale 1ns/1ps
module pwm_trip_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trip_ni = 1'b1;
  logic [5:0]  gate_i = 6'b101101;
  logic        sync_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [5:0]  gate_o;
  logic        sync_o, run_o, en_o;
  logic [15:0] status_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwm_trip_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .trip_ni(trip_ni), .gate_i(gate_i),
    .sync_i(sync_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .gate_o(gate_o), .sync_o(sync_o),
    .run_o(run_o), .en_o(en_o), .status_o(status_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
    #0.5;
  endtask

  task automatic write_timing_regs();
    for (int i = 2; i < 6; i++) wr(3'(i), 16'h0);
  endtask

  task automatic t_reset();
    #0.5;
    check("R9 en", en_o, 0);
    check("R9 run", run_o, 1);
    check("R9 status", status_o, 32'h0008);
    check("R9 gate", gate_o, 0);
  endtask

  task automatic t_pass_sync();
    wr(3'd0, 16'h0001);
    check("R1 pass", gate_o, 6'b101101);
    gate_i = 6'b010011; #0.5;
    check("R1 pass2", gate_o, 6'b010011);
    @(negedge clk_i); sync_i = 1'b1; #0.5;
    check("R2 sync pass", sync_o, 1);
    @(negedge clk_i); sync_i = 1'b0; #0.5;
    check("R7 sync flag", status_o[9], 1);
    wr(3'd1, 16'h0000);
    check("R8 zero keeps", status_o[9], 1);
    wr(3'd1, 16'h0200);
    check("R8 clear sync", status_o[9], 0);
  endtask

  task automatic t_trip();
    @(negedge clk_i); trip_ni = 1'b0; sync_i = 1'b1; #0.5;
    check("R1 async kill", gate_o, 0);
    check("R2 sync blocked", sync_o, 0);
    @(negedge clk_i); sync_i = 1'b0; #0.5;
    check("R7 pin after 1", status_o[3], 1);
    @(negedge clk_i); #0.5;
    check("R7 pin after 2", status_o[3], 0);
    check("R3 run before 3", run_o, 1);
    @(negedge clk_i); #0.5;
    check("R3 tripped", run_o, 0);
    check("R3 trip flag", status_o[8], 1);
    check("R4 en cleared", en_o, 0);
  endtask

  task automatic t_partial_then_full();
    wr(3'd2, 16'h0); wr(3'd3, 16'h0); wr(3'd4, 16'h0);
    @(negedge clk_i); trip_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    #0.5;
    check("R6 partial stays", run_o, 0);
    wr(3'd0, 16'h0001);
    check("R1 tripped gate", gate_o, 0);
    wr(3'd5, 16'h0);
    check("R5 not yet", run_o, 0);
    @(negedge clk_i); #0.5;
    check("R5 rearm", run_o, 1);
    check("R1 resumed", gate_o, gate_i);
    check("R8 sticky trip", status_o[8], 1);
    wr(3'd1, 16'h0100);
    check("R8 clear trip", status_o[8], 0);
  endtask

  task automatic t_collide_w1c();
    @(negedge clk_i); trip_ni = 1'b0;
    @(negedge clk_i);
    wr(3'd1, 16'h0100);  // lands on third edge
    check("R8 set wins", status_o[8], 1);
    check("R3 tripped2", run_o, 0);
    write_timing_regs();
    @(negedge clk_i); trip_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    #0.5;
    check("R5 rearm early writes", run_o, 1);
  endtask

  task automatic t_collide_en();
    wr(3'd0, 16'h0001);
    check("R4 en set", en_o, 1);
    @(negedge clk_i); trip_ni = 1'b0;
    @(negedge clk_i);
    wr(3'd0, 16'h0001);  // lands on third edge
    check("R4 trip beats write", en_o, 0);
    @(negedge clk_i); trip_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    #0.5;
    check("R6 old writes void", run_o, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_pass_sync();
    t_trip();
    t_partial_then_full();
    t_collide_w1c();
    t_collide_en();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule